// File: doc/BRIEF.md
# Prescaled Down-Counting Timer Channel

This block is a single programmable timer channel. It takes a one-cycle tick from a timer clock domain and divides it by 1, 16 or 256. It then decrements a counter that runs at 16-bit or 32-bit width and sets an interrupt flag when the count reaches zero. Once the count is zero, the next tick either wraps it to all ones (free-running) or reloads it from a stored load value (periodic). In one-shot mode the channel halts after it expires.

Software reaches the channel through a simple register port: a write strobe, a 3-bit register select, write data, and combinational read data for the selected register. There are two load paths. One is immediate and replaces the count at once. The other is background and takes effect only at the next reload. The width can change at run time; while the counter runs at 16 bits, the upper half of the count is held and comes back when it returns to 32 bits. Bus protocol decoding, identification registers and test-mode output muxing belong to a wrapper around this block.

Top module: `tick_down_timer`

## Requirements
- R1: After reset, CTRL reads 0x20 (disabled, free-running, 16-bit, interrupt enable set), LOAD reads 0, VALUE reads 0xFFFFFFFF, RIS and MIS read 0, and irq_o is low.
- R2: The select codes are 0 LOAD, 1 VALUE, 2 CTRL, 3 interrupt clear (write only), 4 RIS, 5 MIS and 6 background load. Both load selects read back the stored load value, and every unused code reads 0.
- R3: CTRL fields are: bit0 one-shot, bit1 size (1 = 32-bit), bits 3:2 prescale, bit5 interrupt enable, bit6 mode (1 = periodic), bit7 enable. All other bits are dropped on write and read as 0.
- R4: A LOAD write stores the value and also copies it into the count in the next cycle. A background-load write stores the value and leaves the count unchanged.
- R5: Each prescaled tick decrements the count by one. In free-running mode, the tick after the count reaches zero sets the count to all ones of the active width.
- R6: In periodic mode, the tick after the count reaches zero reloads the count from the stored load value, including a value written through the background path.
- R7: RIS is set only when a decrement lands on zero, never by a load. Any write to the clear select clears RIS. MIS equals RIS AND interrupt enable, and irq_o equals MIS.
- R8: In one-shot mode the count halts at zero after it expires. A nonzero LOAD write while enabled restarts it, and so does any CTRL write with enable set, even if enable was already set.
- R9: In periodic mode, a LOAD write whose value is zero in the active width stops counting, even when a later background load would give a nonzero reload value.
- R10: At 16-bit width only bits 15:0 count and wrap. Bits 31:16 of VALUE are held, and they are counted again after a switch back to 32-bit width.
- R11: Prescale code 00 divides ticks by 1, 01 by 16, and 10 and 11 both by 256. The prescaler restarts when the prescale field changes.
- R12: Ticks are ignored while enable is clear. A tick in the same cycle as a CTRL write does not count, so disabling takes effect before that tick and enabling takes effect only after the new settings are in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle timer tick |
| wr_en_i | input | 1 | Register write strobe |
| sel_i | input | 3 | Register select for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Masked interrupt |

## Verification
The hardest state to reach is an expired one-shot timer, and the two ways out of it. To get there, the stimulus runs the count to zero in one-shot periodic mode. It then confirms that further ticks leave the count at zero. After that it leaves the halt once by rewriting CTRL with an unchanged value and once by a nonzero LOAD write. The stimulus also places ticks in the same cycle as CTRL writes to pin down which changes apply first. It issues 256 ticks after the reserved prescale code is set, to show that the restarted prescaler divides by 256.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    SEL_LOAD  = 3'd0,
    SEL_VALUE = 3'd1,
    SEL_CTRL  = 3'd2,
    SEL_ICLR  = 3'd3,
    SEL_RIS   = 3'd4,
    SEL_MIS   = 3'd5,
    SEL_BGLD  = 3'd6,
    SEL_NONE  = 3'd7
  } tmr_sel_e;

  typedef struct packed {
    logic       en;
    logic       periodic;
    logic       inten;
    logic       rsvd;
    logic [1:0] pre;
    logic       size32;
    logic       oneshot;
  } tmr_ctrl_t;

  localparam logic [7:0] CTRL_WMASK = 8'hEF;
  localparam logic [7:0] CTRL_RST   = 8'h20;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int MID_LOG = 4,
  parameter int MAX_LOG = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       tick_i,
  input  logic [1:0] code_i,
  input  logic       restart_i,
  output logic       pulse_o
);
  localparam int PW = MAX_LOG;
  localparam logic [PW-1:0] LIM_MID = PW'((1 << MID_LOG) - 1);
  localparam logic [PW-1:0] LIM_MAX = PW'((1 << MAX_LOG) - 1);

  logic [PW-1:0] cnt_q, limit;
  logic          at_lim;

  always_comb begin
    unique case (code_i)
      2'b00:   limit = '0;
      2'b01:   limit = LIM_MID;
      default: limit = LIM_MAX; // reserved code aliases the slowest divide
    endcase
  end

  assign at_lim  = (cnt_q >= limit);
  assign pulse_o = run_i & tick_i & at_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (restart_i)       cnt_q <= '0;
    else if (run_i && tick_i) cnt_q <= at_lim ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W  = 32,
  parameter int HALF_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             en_i,
  input  logic             size32_i,
  input  logic             periodic_i,
  input  logic             oneshot_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             ld_wr_i,
  input  logic [CNT_W-1:0] ld_data_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] count_o,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] HALF_MASK = {{(CNT_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

  logic [CNT_W-1:0] count_q, mask, cur, dec, fill, nxt;
  logic             halted_q, do_step, is_zero, ld_zero;

  assign mask    = size32_i ? '1 : HALF_MASK;
  assign cur     = count_q & mask;
  assign is_zero = (cur == '0);
  assign dec     = (cur - 1'b1) & mask;
  assign fill    = periodic_i ? (reload_i & mask) : mask;
  assign nxt     = (count_q & ~mask) | (is_zero ? fill : dec);
  assign ld_zero = ((ld_data_i & mask) == '0);
  assign do_step = step_i & ~halted_q & ~ld_wr_i;
  assign hit_o   = do_step & ~is_zero & (dec == '0);
  assign count_o = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '1;
    end else if (ld_wr_i) begin
      count_q <= ld_data_i;
    end else if (do_step) begin
      count_q <= nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halted_q <= 1'b0;
    end else if (restart_i) begin
      halted_q <= 1'b0;
    end else if (ld_wr_i) begin
      if (periodic_i && ld_zero)  halted_q <= 1'b1;
      else if (en_i && !ld_zero)  halted_q <= 1'b0;
    end else if (hit_o && oneshot_i) begin
      halted_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr_irq_status.sv
module tmr_irq_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_i,
  input  logic inten_i,
  output logic ris_o,
  output logic mis_o
);
  logic ris_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ris_q <= 1'b0;
    else if (hit_i)  ris_q <= 1'b1; // a fresh expiry beats a coincident clear
    else if (clr_i)  ris_q <= 1'b0;
  end

  assign ris_o = ris_q;
  assign mis_o = ris_q & inten_i;
endmodule

// File: rtl/tick_down_timer.sv
module tick_down_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int MID_LOG = 4,
  parameter int MAX_LOG = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        wr_en_i,
  input  logic [2:0]  sel_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  localparam int HALF_W = CNT_W / 2;

  tmr_sel_e         sel;
  tmr_ctrl_t        ctrl_q, ctrl_new;
  logic [CNT_W-1:0] load_q, count_w;
  logic             ctrl_wr, ld_wr, bg_wr, clr_wr;
  logic             pulse, hit_w, ris_w, mis_w;

  assign sel      = tmr_sel_e'(sel_i);
  assign ctrl_wr  = wr_en_i && (sel == SEL_CTRL);
  assign ld_wr    = wr_en_i && (sel == SEL_LOAD);
  assign bg_wr    = wr_en_i && (sel == SEL_BGLD);
  assign clr_wr   = wr_en_i && (sel == SEL_ICLR);
  assign ctrl_new = tmr_ctrl_t'(wdata_i[7:0] & CTRL_WMASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= tmr_ctrl_t'(CTRL_RST);
      load_q <= '0;
    end else begin
      if (ctrl_wr)         ctrl_q <= ctrl_new;
      if (ld_wr || bg_wr)  load_q <= wdata_i[CNT_W-1:0];
    end
  end

  tmr_prescale #(.MID_LOG(MID_LOG), .MAX_LOG(MAX_LOG)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (ctrl_q.en),
    .tick_i    (tick_i),
    .code_i    (ctrl_q.pre),
    .restart_i (ctrl_wr && (ctrl_new.pre != ctrl_q.pre)),
    .pulse_o   (pulse)
  );

  tmr_count_core #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (pulse && !ctrl_wr),
    .en_i       (ctrl_q.en),
    .size32_i   (ctrl_q.size32),
    .periodic_i (ctrl_q.periodic),
    .oneshot_i  (ctrl_q.oneshot),
    .reload_i   (load_q),
    .ld_wr_i    (ld_wr),
    .ld_data_i  (wdata_i[CNT_W-1:0]),
    .restart_i  (ctrl_wr && ctrl_new.en),
    .count_o    (count_w),
    .hit_o      (hit_w)
  );

  tmr_irq_status u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit_w),
    .clr_i   (clr_wr),
    .inten_i (ctrl_q.inten),
    .ris_o   (ris_w),
    .mis_o   (mis_w)
  );

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_LOAD, SEL_BGLD: rdata_o = 32'(load_q);
      SEL_VALUE:          rdata_o = 32'(count_w);
      SEL_CTRL:           rdata_o = {24'h0, ctrl_q};
      SEL_RIS:            rdata_o = {31'h0, ris_w};
      SEL_MIS:            rdata_o = {31'h0, mis_w};
      default:            rdata_o = '0;
    endcase
  end

  assign irq_o = mis_w;
endmodule

// File: rtl/tick_down_timer_chk.sv
module tick_down_timer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick_i,
  input logic        wr_en_i,
  input logic [2:0]  sel_i,
  input logic [31:0] wdata_i,
  input logic        irq_o,
  input logic [31:0] count_i,
  input logic        ris_i,
  input logic        en_i,
  input logic        size32_i
);
  logic ld_w, bg_w, clr_w;
  assign ld_w  = wr_en_i && (sel_i == 3'd0);
  assign clr_w = wr_en_i && (sel_i == 3'd3);
  assign bg_w  = wr_en_i && (sel_i == 3'd6);

  AST_LOAD_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_w |=> count_i == $past(wdata_i)); // R4
  AST_BG_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bg_w && !tick_i |=> $stable(count_i)); // R4
  AST_NO_LOAD_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_w && !ris_i |=> !ris_i); // R7
  AST_CLR_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_w && !tick_i |=> !irq_o); // R7
  AST_UPPER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !size32_i && !ld_w |=> $stable(count_i[31:16])); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !ld_w |=> $stable(count_i)); // R12
endmodule

bind tick_down_timer tick_down_timer_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .wr_en_i  (wr_en_i),
  .sel_i    (sel_i),
  .wdata_i  (wdata_i),
  .irq_o    (irq_o),
  .count_i  (32'(count_w)),
  .ris_i    (ris_w),
  .en_i     (ctrl_q.en),
  .size32_i (ctrl_q.size32)
);

// File: tb/tick_down_timer_test.sv
module tick_down_timer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  sel_i = 3'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  localparam logic [2:0] S_LOAD = 3'd0, S_VAL = 3'd1, S_CTRL = 3'd2, S_CLR = 3'd3,
                         S_RIS = 3'd4, S_MIS = 3'd5, S_BG = 3'd6, S_NONE = 3'd7;

  always #2.5 clk_i = ~clk_i;

  tick_down_timer uut (.*);

  typedef struct {
    logic [2:0]  sel;
    logic [31:0] exp;
    logic        exp_irq;
    string       req;
  } sb_item_t;

  sb_item_t sb_q[$];
  int n_chk = 0, n_fail = 0, n_push = 0, n_seen = 0;
  bit done = 0;

  initial forever begin
    wait (sb_q.size() != 0);
    #1;
    begin
      sb_item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (rdata_o !== it.exp || irq_o !== it.exp_irq) begin
        n_fail++;
        $display("FAIL %s sel=%0d rdata=%h irq=%b expected rdata=%h irq=%b",
                 it.req, it.sel, rdata_o, irq_o, it.exp, it.exp_irq);
      end
      n_seen++;
    end
  end

  task automatic expect_reg(input logic [2:0] s, input logic [31:0] e, input logic ei, input string r);
    sb_item_t it;
    @(negedge clk_i);
    wr_en_i = 0; sel_i = s;
    it.sel = s; it.exp = e; it.exp_irq = ei; it.req = r;
    sb_q.push_back(it);
    n_push++;
    wait (n_seen == n_push);
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d, input bit with_tick = 0);
    @(negedge clk_i);
    wr_en_i = 1; sel_i = s; wdata_i = d; tick_i = with_tick;
    @(negedge clk_i);
    wr_en_i = 0; tick_i = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      tick_i = 1;
    end
    @(negedge clk_i);
    tick_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    expect_reg(S_CTRL, 32'h20, 0, "R1");
    expect_reg(S_LOAD, 32'h0, 0, "R1");
    expect_reg(S_VAL, 32'hFFFFFFFF, 0, "R1");
    expect_reg(S_RIS, 32'h0, 0, "R1");
    expect_reg(S_MIS, 32'h0, 0, "R1");
    expect_reg(S_NONE, 32'h0, 0, "R2");
    // R12 disabled ignores ticks
    ticks(3);
    expect_reg(S_VAL, 32'hFFFFFFFF, 0, "R12");
    // R4 immediate load, R3 field layout
    wr(S_LOAD, 32'd5);
    expect_reg(S_VAL, 32'd5, 0, "R4");
    wr(S_CTRL, 32'hFFFFFF10 | 32'hA2);
    expect_reg(S_CTRL, 32'hA2, 0, "R3");
    // R5 decrement and free-running wrap, R7 flag
    ticks(4);
    expect_reg(S_VAL, 32'd1, 0, "R5");
    expect_reg(S_RIS, 32'd0, 0, "R7");
    ticks(1);
    expect_reg(S_VAL, 32'd0, 1, "R5");
    expect_reg(S_RIS, 32'd1, 1, "R7");
    expect_reg(S_MIS, 32'd1, 1, "R7");
    ticks(1);
    expect_reg(S_VAL, 32'hFFFFFFFF, 1, "R5");
    wr(S_CLR, 32'h0);
    expect_reg(S_RIS, 32'd0, 0, "R7");
    // R7 masking
    wr(S_CTRL, 32'h82);
    wr(S_LOAD, 32'd1);
    ticks(1);
    expect_reg(S_RIS, 32'd1, 0, "R7");
    expect_reg(S_MIS, 32'd0, 0, "R7");
    wr(S_CLR, 32'h0);
    // R10 16-bit counting with upper half held
    wr(S_CTRL, 32'hA0);
    wr(S_LOAD, 32'h12340002);
    expect_reg(S_VAL, 32'h12340002, 0, "R10");
    ticks(2);
    expect_reg(S_VAL, 32'h12340000, 1, "R10");
    ticks(1);
    expect_reg(S_VAL, 32'h1234FFFF, 1, "R10");
    wr(S_CTRL, 32'hA2);
    ticks(1);
    expect_reg(S_VAL, 32'h1234FFFE, 1, "R10");
    wr(S_CLR, 32'h0);
    // R6 periodic reload with background load
    wr(S_CTRL, 32'hE2);
    wr(S_LOAD, 32'd3);
    wr(S_BG, 32'd7);
    expect_reg(S_VAL, 32'd3, 0, "R4");
    expect_reg(S_BG, 32'd7, 0, "R2");
    expect_reg(S_LOAD, 32'd7, 0, "R2");
    ticks(3);
    expect_reg(S_VAL, 32'd0, 1, "R6");
    ticks(1);
    expect_reg(S_VAL, 32'd7, 1, "R6");
    wr(S_CLR, 32'h0);
    // R9 zero load stops periodic counting
    wr(S_LOAD, 32'd0);
    wr(S_BG, 32'd5);
    ticks(3);
    expect_reg(S_VAL, 32'd0, 0, "R9");
    expect_reg(S_RIS, 32'd0, 0, "R7");
    wr(S_LOAD, 32'd4);
    ticks(1);
    expect_reg(S_VAL, 32'd3, 0, "R8");
    // R8 one-shot
    wr(S_CTRL, 32'hE3);
    wr(S_LOAD, 32'd2);
    ticks(2);
    expect_reg(S_VAL, 32'd0, 1, "R8");
    wr(S_CLR, 32'h0);
    ticks(2);
    expect_reg(S_VAL, 32'd0, 0, "R8");
    wr(S_CTRL, 32'hE3);
    ticks(1);
    expect_reg(S_VAL, 32'd2, 0, "R8");
    ticks(2);
    expect_reg(S_VAL, 32'd0, 1, "R8");
    wr(S_LOAD, 32'd3);
    ticks(1);
    expect_reg(S_VAL, 32'd2, 1, "R8");
    wr(S_CLR, 32'h0);
    // R11 prescaler
    wr(S_CTRL, 32'hA6);
    wr(S_LOAD, 32'd100);
    ticks(15);
    expect_reg(S_VAL, 32'd100, 0, "R11");
    ticks(1);
    expect_reg(S_VAL, 32'd99, 0, "R11");
    wr(S_CTRL, 32'hAE);
    ticks(255);
    expect_reg(S_VAL, 32'd99, 0, "R11");
    ticks(1);
    expect_reg(S_VAL, 32'd98, 0, "R11");
    // R12 tick coinciding with control writes
    wr(S_CTRL, 32'hA2);
    wr(S_LOAD, 32'd10);
    wr(S_CTRL, 32'h22, 1);
    expect_reg(S_VAL, 32'd10, 0, "R12");
    ticks(3);
    expect_reg(S_VAL, 32'd10, 0, "R12");
    wr(S_CTRL, 32'hA2, 1);
    expect_reg(S_VAL, 32'd10, 0, "R12");
    ticks(1);
    expect_reg(S_VAL, 32'd9, 0, "R12");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule